// File: doc/BRIEF.md
# Sample Phase Tuning Engine

This block finds a good receive sampling phase for a memory-card host. When the host controller pulses `start_i`, the engine captures the current 3-bit phase. It then steps the phase forward through all eight positions, wrapping modulo 8, and asks the command engine to run one tuning trial per position. Each trial returns a single pass bit. The passing positions build up an 8-bit candidate mask, in which bit p stands for phase p.

Once the sweep is over, the engine chooses a phase by scanning the mask one index per clock, in three priority passes:
1. It looks for a five-wide passing window.
2. If none exists, it looks for a three-wide passing window.
3. If neither exists, it takes the lowest passing phase.

A chosen phase is stored, written out with a one-cycle write strobe, and kept as the tuned value for later speed-mode changes. If the mask is empty, the engine raises an error and keeps the previously tuned phase.

The trial interface is a request with back-pressure. `trial_valid_o` rises with a phase and a maximum timeout value. Both stay frozen until the command engine returns `trial_rsp_valid_i` for one cycle, together with `trial_pass_i`. The response therefore acts as the ready of the request. A response that arrives while no request is open is dropped. After a response, the next request can appear in the very next cycle.

Top module: `phase_tune_engine`

## Requirements
- R1: After reset, `done_o`, `err_o`, `phase_wr_o` and `trial_valid_o` are 0, and `phase_o` equals 0.
- R2: A start captures `cur_phase_i` as c. Exactly eight trials follow, at phases c+1, c+2, ..., c+8, all modulo 8, so the last trial is at c itself.
- R3: While `trial_valid_o` is high and no response has arrived, `trial_valid_o` and `trial_phase_o` stay unchanged. A response pulse while no request is open changes nothing.
- R4: Whenever `trial_valid_o` is high, `trial_tmo_o` is all ones.
- R5: A passing trial at phase p sets bit p of the candidate mask. The mask is cleared at every start, and only phases whose bit is set can be chosen.
- R6: The result is the lowest i (0..7) for which phases i-2, i-1, i, i+1 and i+2 (modulo 8) all passed. This is the mask rotated right by i, ANDed with 0xC7, giving 0xC7.
- R7: If no i satisfies R6, the result is the lowest i for which phases i-1, i and i+1 (modulo 8) passed. This is the rotated mask ANDed with 0x83, giving 0x83.
- R8: If neither R6 nor R7 finds a phase, the result is the lowest phase that passed.
- R9: If no trial passed, the sweep ends with `done_o` and `err_o` high, `phase_o` unchanged and no `phase_wr_o`.
- R10: On success, `phase_o` takes the chosen phase, `phase_wr_o` pulses in the same cycle as `done_o`, and `err_o` is 0.
- R11: A start that arrives while a sweep or selection is running is ignored. It neither restarts the trial order nor produces a second `done_o`.
- R12: `done_o` is a one-cycle pulse, issued once per accepted start. After it, no trial request is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a tuning sweep (accepted only when idle) |
| cur_phase_i | input | 3 | Current sample phase, captured at start |
| trial_valid_o | output | 1 | Trial request open |
| trial_phase_o | output | 3 | Phase to test in the open trial |
| trial_tmo_o | output | 32 | Timeout setting for the trial, all ones while requesting |
| trial_rsp_valid_i | input | 1 | One-cycle trial response; closes the request |
| trial_pass_i | input | 1 | Trial outcome, qualified by `trial_rsp_valid_i` |
| done_o | output | 1 | One-cycle pulse when a result or an error is ready |
| err_o | output | 1 | No phase passed in the last sweep; held until the next result |
| phase_o | output | 3 | Stored tuned phase |
| phase_wr_o | output | 1 | One-cycle write strobe for `phase_o` into the sample-phase field |

## Verification
The assertions assume the following about the inputs:
- The command engine raises `trial_rsp_valid_i` for a single cycle, and only while a request is open.
- `trial_pass_i` carries meaning only in that cycle.
- `start_i` is a level that the engine samples once, while idle.

The bench's responder follows these rules. It waits until it sees the request, optionally stalls for a few cycles, and then pulses the response for exactly one cycle with the pass bit taken from the row's mask at the requested phase. Any start or response outside these conditions is injected on purpose, in directed tests, to show that it has no effect.

// File: rtl/tune_pkg.sv
`timescale 1ns/1ps
package tune_pkg;
  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_TRIAL = 2'd1,
    SW_PICK  = 2'd2
  } sweep_state_e;
endpackage

// File: rtl/tune_window.sv
`timescale 1ns/1ps
// Reports whether every phase within +/-HALF of a centre passed.
module tune_window #(
  parameter int PW   = 3,
  parameter int HALF = 2
) (
  input  logic [(2**PW)-1:0] mask_i,
  input  logic [PW-1:0]      centre_i,
  output logic               hit_o
);
  localparam int SPAN = 2 * HALF + 1;

  logic [SPAN-1:0] taps;

  for (genvar d = 0; d < SPAN; d++) begin : g_tap
    logic [PW-1:0] pos;
    // Phase arithmetic wraps naturally because the phase count is a power of two.
    assign pos     = centre_i + PW'(d) - PW'(HALF);
    assign taps[d] = mask_i[pos];
  end

  assign hit_o = &taps;
endmodule

// File: rtl/tune_select.sv
`timescale 1ns/1ps
// Sequential picker: one candidate index per clock, with passes in priority order.
module tune_select #(
  parameter int PW        = 3,
  parameter int WIDE_HALF = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_i,
  input  logic [(2**PW)-1:0]  mask_i,
  output logic                res_valid_o,
  output logic                res_found_o,
  output logic [PW-1:0]       res_idx_o
);
  localparam int N      = 2 ** PW;
  localparam int NPASS  = WIDE_HALF + 1;
  localparam int PASS_W = (NPASS > 1) ? $clog2(NPASS) : 1;

  logic              busy_q;
  logic [PASS_W-1:0] pass_q;
  logic [PW-1:0]     idx_q;
  logic [N-1:0]      mask_q;
  logic [NPASS-1:0]  hits;
  logic              hit_now;
  logic              last_idx;
  logic              last_pass;

  // Pass g tests a window of half-width WIDE_HALF-g; the final pass is a single bit.
  for (genvar g = 0; g < NPASS; g++) begin : g_pass
    tune_window #(
      .PW  (PW),
      .HALF(WIDE_HALF - g)
    ) u_win (
      .mask_i  (mask_q),
      .centre_i(idx_q),
      .hit_o   (hits[g])
    );
  end

  assign hit_now   = hits[pass_q];
  assign last_idx  = (idx_q == PW'(N - 1));
  assign last_pass = (pass_q == PASS_W'(NPASS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      pass_q      <= '0;
      idx_q       <= '0;
      mask_q      <= '0;
      res_valid_o <= 1'b0;
      res_found_o <= 1'b0;
      res_idx_o   <= '0;
    end else begin
      res_valid_o <= 1'b0;
      if (go_i && !busy_q) begin
        busy_q <= 1'b1;
        pass_q <= '0;
        idx_q  <= '0;
        mask_q <= mask_i;
      end else if (busy_q) begin
        if (hit_now) begin
          busy_q      <= 1'b0;
          res_valid_o <= 1'b1;
          res_found_o <= 1'b1;
          res_idx_o   <= idx_q;
        end else if (last_idx) begin
          idx_q <= '0;
          if (last_pass) begin
            busy_q      <= 1'b0;
            res_valid_o <= 1'b1;
            res_found_o <= 1'b0;
          end else begin
            pass_q <= pass_q + PASS_W'(1);
          end
        end else begin
          idx_q <= idx_q + PW'(1);
        end
      end
    end
  end

  // A chosen phase must be one that passed (R5).
  p_pick_passed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_found_o) |-> mask_q[res_idx_o]);

  // The scan never walks past its last pass (R8).
  p_pass_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (pass_q <= PASS_W'(NPASS - 1)));

  // A miss on every pass is only possible for an empty mask (R9).
  p_err_only_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_found_o) |-> (mask_q == '0));
endmodule

// File: rtl/tune_sweep.sv
`timescale 1ns/1ps
// Steps the phase through all positions, issues one trial per phase, and builds the mask.
module tune_sweep
  import tune_pkg::*;
#(
  parameter int PW    = 3,
  parameter int TMO_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [PW-1:0]       cur_phase_i,
  output logic                req_valid_o,
  output logic [PW-1:0]       req_phase_o,
  output logic [TMO_W-1:0]    req_tmo_o,
  input  logic                rsp_valid_i,
  input  logic                rsp_pass_i,
  output logic                pick_go_o,
  output logic [(2**PW)-1:0]  mask_o,
  input  logic                pick_done_i
);
  localparam int N = 2 ** PW;

  sweep_state_e  state_q;
  logic [PW-1:0] origin_q;
  logic [PW-1:0] ph_q;
  logic [N-1:0]  mask_q;
  logic          go_q;
  logic [PW:0]   trials_q;

  assign req_valid_o = (state_q == SW_TRIAL);
  assign req_phase_o = ph_q;
  assign req_tmo_o   = {TMO_W{req_valid_o}};
  assign pick_go_o   = go_q;
  assign mask_o      = mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SW_IDLE;
      origin_q <= '0;
      ph_q     <= '0;
      mask_q   <= '0;
      go_q     <= 1'b0;
      trials_q <= '0;
    end else begin
      go_q <= 1'b0;
      unique case (state_q)
        SW_IDLE: begin
          if (start_i) begin
            origin_q <= cur_phase_i;
            ph_q     <= cur_phase_i + PW'(1);
            mask_q   <= '0;
            trials_q <= '0;
            state_q  <= SW_TRIAL;
          end
        end
        SW_TRIAL: begin
          if (rsp_valid_i) begin
            mask_q[ph_q] <= rsp_pass_i;
            trials_q     <= trials_q + (PW+1)'(1);
            if (ph_q == origin_q) begin
              state_q <= SW_PICK;
              go_q    <= 1'b1;
            end else begin
              ph_q <= ph_q + PW'(1);
            end
          end
        end
        SW_PICK: begin
          if (pick_done_i) state_q <= SW_IDLE;
        end
        default: state_q <= SW_IDLE;
      endcase
    end
  end

  // A request stays open and unchanged until it is answered (R3).
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !rsp_valid_i) |=> (req_valid_o && $stable(req_phase_o)));

  // Selection begins only after exactly one trial per phase (R2).
  p_all_phases_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pick_go_o |-> (trials_q == (PW+1)'(N)));

  // A busy sweep keeps its starting phase whatever start does (R11).
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SW_IDLE) |=> $stable(origin_q));
endmodule

// File: rtl/phase_tune_engine.sv
`timescale 1ns/1ps
module phase_tune_engine #(
  parameter int PW          = 3,
  parameter int TMO_W       = 32,
  parameter int WIDE_HALF   = 2,
  parameter int RESET_PHASE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [PW-1:0]    cur_phase_i,
  output logic             trial_valid_o,
  output logic [PW-1:0]    trial_phase_o,
  output logic [TMO_W-1:0] trial_tmo_o,
  input  logic             trial_rsp_valid_i,
  input  logic             trial_pass_i,
  output logic             done_o,
  output logic             err_o,
  output logic [PW-1:0]    phase_o,
  output logic             phase_wr_o
);
  localparam int N = 2 ** PW;

  logic          pick_go;
  logic [N-1:0]  cand_mask;
  logic          sel_valid;
  logic          sel_found;
  logic [PW-1:0] sel_idx;

  logic          done_q;
  logic          err_q;
  logic [PW-1:0] phase_q;
  logic          wr_q;

  tune_sweep #(
    .PW   (PW),
    .TMO_W(TMO_W)
  ) u_sweep (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cur_phase_i(cur_phase_i),
    .req_valid_o(trial_valid_o),
    .req_phase_o(trial_phase_o),
    .req_tmo_o  (trial_tmo_o),
    .rsp_valid_i(trial_rsp_valid_i),
    .rsp_pass_i (trial_pass_i),
    .pick_go_o  (pick_go),
    .mask_o     (cand_mask),
    .pick_done_i(sel_valid)
  );

  tune_select #(
    .PW       (PW),
    .WIDE_HALF(WIDE_HALF)
  ) u_select (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (pick_go),
    .mask_i     (cand_mask),
    .res_valid_o(sel_valid),
    .res_found_o(sel_found),
    .res_idx_o  (sel_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      phase_q <= PW'(RESET_PHASE);
      wr_q    <= 1'b0;
    end else begin
      done_q <= sel_valid;
      wr_q   <= sel_valid && sel_found;
      if (sel_valid) begin
        err_q <= !sel_found;
        if (sel_found) phase_q <= sel_idx;
      end
    end
  end

  assign done_o     = done_q;
  assign err_o      = err_q;
  assign phase_o    = phase_q;
  assign phase_wr_o = wr_q;

  // Completion is a single-cycle pulse (R12).
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // An empty sweep flags an error and leaves the tuned phase alone (R9).
  p_err_keeps_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !sel_found) |=> (err_o && done_o && $stable(phase_o)));

  // The write strobe appears only with a successful completion (R10).
  p_wr_only_success_r10: assert property (@(posedge clk) disable iff (!rst_n)
    phase_wr_o |-> (done_o && !err_o));
endmodule

// File: tb/test_phase_tune_engine.sv
`timescale 1ns/1ps
module test_phase_tune_engine;
  localparam int PW    = 3;
  localparam int N     = 8;
  localparam int TMO_W = 32;

  typedef struct packed {
    logic [2:0] cur;
    logic [7:0] mask;
    logic [3:0] delay;
    logic       err;
    logic [2:0] phase;
  } vec_t;

  // cur, mask, responder stall, expected err, expected phase
  localparam vec_t VECS [10] = '{
    '{3'd0, 8'hFF, 4'd0, 1'b0, 3'd0},  // R6 full mask
    '{3'd3, 8'h7C, 4'd1, 1'b0, 3'd4},  // R6 window 2..6
    '{3'd7, 8'h83, 4'd2, 1'b0, 3'd0},  // R7 window wraps 7,0,1
    '{3'd1, 8'h0E, 4'd0, 1'b0, 3'd2},  // R7 window 1..3
    '{3'd5, 8'h50, 4'd3, 1'b0, 3'd4},  // R8 lowest of 4,6
    '{3'd2, 8'h00, 4'd1, 1'b1, 3'd4},  // R9 empty keeps 4
    '{3'd6, 8'hE3, 4'd0, 1'b0, 3'd7},  // R6 beats R7 (would give 0)
    '{3'd4, 8'h80, 4'd2, 1'b0, 3'd7},  // R8 single bit 7
    '{3'd0, 8'h71, 4'd1, 1'b0, 3'd5},  // R7 beats R8 (would give 0)
    '{3'd5, 8'h01, 4'd0, 1'b0, 3'd0}   // R8 single bit 0
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [PW-1:0]    cur_phase_i = '0;
  logic             trial_valid_o;
  logic [PW-1:0]    trial_phase_o;
  logic [TMO_W-1:0] trial_tmo_o;
  logic             trial_rsp_valid_i = 1'b0;
  logic             trial_pass_i = 1'b0;
  logic             done_o;
  logic             err_o;
  logic [PW-1:0]    phase_o;
  logic             phase_wr_o;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  phase_tune_engine i_phase_tune_engine (
    .clk              (clk),
    .rst_n            (rst_n),
    .start_i          (start_i),
    .cur_phase_i      (cur_phase_i),
    .trial_valid_o    (trial_valid_o),
    .trial_phase_o    (trial_phase_o),
    .trial_tmo_o      (trial_tmo_o),
    .trial_rsp_valid_i(trial_rsp_valid_i),
    .trial_pass_i     (trial_pass_i),
    .done_o           (done_o),
    .err_o            (err_o),
    .phase_o          (phase_o),
    .phase_wr_o       (phase_wr_o)
  );

  task automatic check(input string req, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One full sweep with a bench responder; optionally injects a start mid-sweep.
  task automatic run_sweep(input vec_t v, input bit inject);
    int bad_order = 0;
    int bad_tmo   = 0;
    int bad_hold  = 0;
    int dones     = 0;
    int waited    = 0;
    logic [PW-1:0] held;
    @(negedge clk);
    cur_phase_i = v.cur;
    start_i     = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < N; k++) begin
      int guard = 0;
      while (!trial_valid_o && guard < 50) begin
        @(negedge clk);
        guard++;
      end
      if (!trial_valid_o || trial_phase_o !== 3'(v.cur + k + 1)) bad_order++;
      if (trial_tmo_o !== '1) bad_tmo++;
      held = trial_phase_o;
      for (int d = 0; d < int'(v.delay); d++) begin
        if (inject && k == 3 && d == 0) begin
          start_i     = 1'b1;
          cur_phase_i = v.cur + 3'd4;
        end else begin
          start_i = 1'b0;
        end
        @(negedge clk);
        if (!trial_valid_o || trial_phase_o !== held) bad_hold++;
      end
      start_i           = 1'b0;
      trial_pass_i      = v.mask[trial_phase_o];
      trial_rsp_valid_i = 1'b1;
      @(negedge clk);
      trial_rsp_valid_i = 1'b0;
      trial_pass_i      = 1'b0;
    end
    check("R2 trial order from start phase", bad_order == 0, bad_order, 0);
    check("R4 timeout all ones", bad_tmo == 0, bad_tmo, 0);
    if (v.delay != 0) check("R3 request held under stall", bad_hold == 0, bad_hold, 0);
    while (!done_o && waited < 60) begin
      @(negedge clk);
      waited++;
    end
    check("R12 done raised", done_o === 1'b1, int'(done_o), 1);
    check("R9 error flag", err_o === v.err, int'(err_o), int'(v.err));
    check("R6|R7|R8|R10 chosen phase", phase_o === v.phase, int'(phase_o), int'(v.phase));
    check("R10 write strobe", phase_wr_o === !v.err, int'(phase_wr_o), int'(!v.err));
    @(negedge clk);
    check("R12 done one cycle", done_o === 1'b0, int'(done_o), 0);
    check("R12 no request after done", trial_valid_o === 1'b0, int'(trial_valid_o), 0);
    if (inject) begin
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (done_o || trial_valid_o) dones++;
      end
      check("R11 start during sweep ignored", dones == 0, dones, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int stray = 0;
    repeat (3) @(negedge clk);
    check("R1 done at reset", done_o === 1'b0, int'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", done_o === 1'b0, int'(done_o), 0);
    check("R1 err after reset", err_o === 1'b0, int'(err_o), 0);
    check("R1 phase after reset", phase_o === 3'd0, int'(phase_o), 0);
    check("R1 strobe after reset", phase_wr_o === 1'b0, int'(phase_wr_o), 0);
    check("R1 no request after reset", trial_valid_o === 1'b0, int'(trial_valid_o), 0);

    // Table walk: R2..R10, R12
    for (int i = 0; i < 10; i++) run_sweep(VECS[i], 1'b0);

    // R3: a response with no request open changes nothing
    trial_rsp_valid_i = 1'b1;
    trial_pass_i      = 1'b1;
    @(negedge clk);
    trial_rsp_valid_i = 1'b0;
    trial_pass_i      = 1'b0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (trial_valid_o || done_o || phase_wr_o) stray++;
    end
    check("R3 stray response ignored", stray == 0, stray, 0);
    check("R3 phase kept after stray response", phase_o === 3'd0, int'(phase_o), 0);

    // R5/R9: mask cleared at start, so an all-fail sweep errors after passing sweeps
    run_sweep('{3'd6, 8'h00, 4'd0, 1'b1, 3'd0}, 1'b0);

    // R11: start pulsed mid-sweep with another phase; order and result unaffected
    run_sweep('{3'd2, 8'h38, 4'd2, 1'b0, 3'd4}, 1'b1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule